// File: doc/BRIEF.md
# Forced Host Role and Speed Controller

This block decides whether a dual-role USB controller acts as host, and which bus speed it reports. Software sets three control bits through a simple write port: one bit forces the host role, and two bits force a speed. A session input tells the block when a session is active. The block also receives a device-connect indication and a one-cycle strobe for each bus reset it sees.

The host role depends on the session, not on an attached device. When the force-host bit is set and a session starts, the controller becomes host. It stays host until that session ends, even if the device leaves. It becomes host again for any later session that starts while the force bit is still set.

The speed code is latched. It takes a new value only on a bus-reset strobe or when the block enters forced host mode. The code is chosen from the force-speed bits, with high speed ahead of full speed. When neither force-speed bit is set, the code comes from a default-speed input.

Top module: `hostforce_ctrl`

## Requirements
- R1: After reset all three control bits are 0, `host_mode_o` is 0 and `op_speed_o` is 2'b00.
- R2: A session start is a cycle with `sess_i` high where it was low in the previous cycle. If the force-host bit is set during a session start, `host_mode_o` goes to 1 on the next clock edge, whatever the level of `dev_conn_i`.
- R3: While `sess_i` stays high, `host_mode_o` stays 1 once it is set, including when `dev_conn_i` falls.
- R4: A cycle with `sess_i` low clears `host_mode_o` on the next clock edge.
- R5: A later session start with the force-host bit still set enters host mode again.
- R6: Clearing the force-host bit during a forced session does not drop host mode at once. Host mode ends when that session ends, and the next session does not enter host mode.
- R7: A `bus_rst_i` strobe while force-high-speed is set loads `op_speed_o` with 2'b01 (high speed).
- R8: A `bus_rst_i` strobe while only force-full-speed is set loads `op_speed_o` with 2'b00 (full speed).
- R9: When both force-speed bits are set, a load gives 2'b01.
- R10: When neither force-speed bit is set, a load copies `dflt_speed_i`.
- R11: Entry into forced host mode also loads the speed code. At any other time, a change in the force bits or in `dflt_speed_i` leaves `op_speed_o` unchanged.
- R12: Setting the force-host bit while a session is already active does not enter host mode. Entry needs a session start.
- R13: When `wr_en_i` is high, the block loads all three control bits from `wr_host_i`, `wr_hs_i` and `wr_fs_i`. The new values take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control bits |
| wr_host_i | input | 1 | Force-host value to write |
| wr_hs_i | input | 1 | Force-high-speed value to write |
| wr_fs_i | input | 1 | Force-full-speed value to write |
| sess_i | input | 1 | Session active level |
| dev_conn_i | input | 1 | Device-connect indication (has no effect on the role) |
| bus_rst_i | input | 1 | One-cycle strobe for a received bus reset |
| dflt_speed_i | input | SPD_W | Speed code used when no force-speed bit is set |
| host_mode_o | output | 1 | Controller is in forced host mode |
| op_speed_o | output | SPD_W | Latched operating-speed code |

## Verification
The bench builds the block with the default code width of two bits. With that width, it can drive default codes 2'b10 and 2'b11, which no force-speed bit can produce. A load that takes the default path can therefore be told apart from one that takes either forced path. The same width lets the bench show that a changed default has no effect until the next load. The bench steps through sessions that repeat, end early, or are already running when the control bits are written, so every route into and out of host mode is taken.

// File: rtl/hostforce_pkg.sv
package hostforce_pkg;

    typedef struct packed {
        logic host;
        logic hs;
        logic fs;
    } force_cfg_t;

    typedef enum logic [0:0] {
        ROLE_PERIPH = 1'b0,
        ROLE_HOST   = 1'b1
    } role_e;

    typedef struct packed {
        role_e role;
        logic  sess_seen;
    } role_st_t;

endpackage

// File: rtl/hostforce_cfg.sv
module hostforce_cfg
    import hostforce_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic       wr_host_i,
    input  logic       wr_hs_i,
    input  logic       wr_fs_i,
    output force_cfg_t cfg_o
);

    force_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            cfg_d.host = wr_host_i;
            cfg_d.hs   = wr_hs_i;
            cfg_d.fs   = wr_fs_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/hostforce_role.sv
module hostforce_role
    import hostforce_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sess_i,
    input  logic force_host_i,
    output logic host_o,
    output logic enter_o
);

    role_st_t st_d, st_q;
    logic     enter;
    logic     sess_start;

    always_comb begin
        st_d           = st_q;
        enter          = 1'b0;
        sess_start     = sess_i && !st_q.sess_seen;
        st_d.sess_seen = sess_i;
        unique case (st_q.role)
            ROLE_PERIPH: begin
                if (sess_start && force_host_i) begin
                    st_d.role = ROLE_HOST;
                    enter     = 1'b1;
                end
            end
            ROLE_HOST: begin
                if (!sess_i) st_d.role = ROLE_PERIPH;
            end
            default: st_d.role = ROLE_PERIPH;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.role      <= ROLE_PERIPH;
            st_q.sess_seen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_o  = (st_q.role == ROLE_HOST);
    assign enter_o = enter;

endmodule

// File: rtl/hostforce_speed.sv
module hostforce_speed #(
    parameter int SPD_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_rst_i,
    input  logic             load_enter_i,
    input  logic             hs_i,
    input  logic             fs_i,
    input  logic [SPD_W-1:0] dflt_i,
    output logic [SPD_W-1:0] speed_o
);

    localparam logic [SPD_W-1:0] CODE_FS = '0;
    localparam logic [SPD_W-1:0] CODE_HS = {{(SPD_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [SPD_W-1:0] code;
    } spd_st_t;

    spd_st_t          spd_d, spd_q;
    logic [SPD_W-1:0] pick;

    always_comb begin
        if (hs_i)      pick = CODE_HS;
        else if (fs_i) pick = CODE_FS;
        else           pick = dflt_i;
        spd_d = spd_q;
        if (load_rst_i || load_enter_i) spd_d.code = pick;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) spd_q.code <= CODE_FS;
        else         spd_q      <= spd_d;
    end

    assign speed_o = spd_q.code;

endmodule

// File: rtl/hostforce_ctrl.sv
module hostforce_ctrl
    import hostforce_pkg::*;
#(
    parameter int SPD_W = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic             wr_host_i,
    input  logic             wr_hs_i,
    input  logic             wr_fs_i,
    input  logic             sess_i,
    input  logic             dev_conn_i,
    input  logic             bus_rst_i,
    input  logic [SPD_W-1:0] dflt_speed_i,
    output logic             host_mode_o,
    output logic [SPD_W-1:0] op_speed_o
);

    force_cfg_t cfg;
    logic       force_host_q, force_hs_q, force_fs_q;
    logic       role_enter;

    hostforce_cfg u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_host_i (wr_host_i),
        .wr_hs_i   (wr_hs_i),
        .wr_fs_i   (wr_fs_i),
        .cfg_o     (cfg)
    );

    assign force_host_q = cfg.host;
    assign force_hs_q   = cfg.hs;
    assign force_fs_q   = cfg.fs;

    hostforce_role u_role (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sess_i       (sess_i),
        .force_host_i (force_host_q),
        .host_o       (host_mode_o),
        .enter_o      (role_enter)
    );

    hostforce_speed #(.SPD_W(SPD_W)) u_speed (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .load_rst_i   (bus_rst_i),
        .load_enter_i (role_enter),
        .hs_i         (force_hs_q),
        .fs_i         (force_fs_q),
        .dflt_i       (dflt_speed_i),
        .speed_o      (op_speed_o)
    );

endmodule

// File: rtl/hostforce_chk.sv
module hostforce_chk #(
    parameter int SPD_W = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sess_i,
    input logic             dev_conn_i,
    input logic             bus_rst_i,
    input logic             force_hs_q,
    input logic             force_fs_q,
    input logic             host_mode_o,
    input logic [SPD_W-1:0] op_speed_o
);

    localparam logic [SPD_W-1:0] CHK_HS = {{(SPD_W-1){1'b0}}, 1'b1};

    AST_ENTRY_NEEDS_SESSION: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(host_mode_o) |-> $past(sess_i)); // R2

    AST_HOLD_ON_DISCONNECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_mode_o && sess_i && !dev_conn_i) |=> host_mode_o); // R3

    AST_EXIT_ON_SESSION_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sess_i |=> !host_mode_o); // R4

    AST_HS_ON_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rst_i && force_hs_q) |=> (op_speed_o == CHK_HS)); // R7

    AST_FS_ON_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rst_i && force_fs_q && !force_hs_q) |=> (op_speed_o == '0)); // R8

    AST_SPEED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_rst_i && !(sess_i && !host_mode_o)) |=> $stable(op_speed_o)); // R11

endmodule

bind hostforce_ctrl hostforce_chk #(.SPD_W(SPD_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sess_i      (sess_i),
    .dev_conn_i  (dev_conn_i),
    .bus_rst_i   (bus_rst_i),
    .force_hs_q  (force_hs_q),
    .force_fs_q  (force_fs_q),
    .host_mode_o (host_mode_o),
    .op_speed_o  (op_speed_o)
);

// File: tb/hostforce_ctrl_tb.sv
module hostforce_ctrl_tb;

    localparam int SPD_W = 2;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             wr_en_i = 1'b0, wr_host_i = 1'b0, wr_hs_i = 1'b0, wr_fs_i = 1'b0;
    logic             sess_i = 1'b0, dev_conn_i = 1'b0, bus_rst_i = 1'b0;
    logic [SPD_W-1:0] dflt_speed_i = '0;
    logic             host_mode_o;
    logic [SPD_W-1:0] op_speed_o;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int m_fh = 0, m_hs = 0, m_fs = 0, m_seen = 0, m_host = 0, m_spd = 0;

    always #5 clk_i = ~clk_i;

    hostforce_ctrl #(.SPD_W(SPD_W)) u_dut (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .wr_host_i    (wr_host_i),
        .wr_hs_i      (wr_hs_i),
        .wr_fs_i      (wr_fs_i),
        .sess_i       (sess_i),
        .dev_conn_i   (dev_conn_i),
        .bus_rst_i    (bus_rst_i),
        .dflt_speed_i (dflt_speed_i),
        .host_mode_o  (host_mode_o),
        .op_speed_o   (op_speed_o)
    );

    task automatic compare(input string tag);
        checks++;
        if (int'(host_mode_o) != m_host) begin
            errors++;
            $display("FAIL %s host_mode actual=%0d expected=%0d", tag, host_mode_o, m_host);
        end
        checks++;
        if (int'(op_speed_o) != m_spd) begin
            errors++;
            $display("FAIL %s op_speed actual=%0d expected=%0d", tag, op_speed_o, m_spd);
        end
    endtask

    // advance model by one clock using the inputs now driven, then compare
    task automatic tick(input string tag);
        int start, enter, nspd, nhost;
        start = (sess_i && !m_seen) ? 1 : 0;
        enter = (!m_host && start && m_fh) ? 1 : 0;
        nspd  = m_spd;
        if (bus_rst_i || enter) nspd = m_hs ? 1 : (m_fs ? 0 : int'(dflt_speed_i));
        nhost = m_host;
        if (enter) nhost = 1;
        else if (m_host && !sess_i) nhost = 0;
        m_spd  = nspd;
        m_host = nhost;
        m_seen = sess_i ? 1 : 0;
        if (wr_en_i) begin
            m_fh = wr_host_i; m_hs = wr_hs_i; m_fs = wr_fs_i;
        end
        @(posedge clk_i);
        @(negedge clk_i);
        compare(tag);
        wr_en_i   = 1'b0;
        bus_rst_i = 1'b0;
    endtask

    task automatic wr(input logic h, input logic hs, input logic fs, input string tag);
        wr_en_i = 1'b1; wr_host_i = h; wr_hs_i = hs; wr_fs_i = fs;
        tick(tag);
    endtask

    task automatic strobe(input string tag);
        bus_rst_i = 1'b1;
        tick(tag);
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk_i);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk_i);
        compare("R1");
        rst_ni = 1'b1;
        tick("R1");
        // R1: control bits are 0 -> session start does not enter host
        sess_i = 1'b1; tick("R1"); tick("R1");
        sess_i = 1'b0; tick("R1");
        // R10: default path with code 2'b10
        dflt_speed_i = 2'b10; strobe("R10");

        // R13 / R2: force host + high speed, session start with no device
        wr(1'b1, 1'b1, 1'b0, "R13");
        sess_i = 1'b1; dev_conn_i = 1'b0; tick("R2");
        tick("R2");
        // R3: device comes and goes
        dev_conn_i = 1'b1; tick("R3");
        dev_conn_i = 1'b0; tick("R3"); tick("R3");
        // R4
        sess_i = 1'b0; tick("R4"); tick("R4");
        // R5: later session re-enters; R7 strobe
        sess_i = 1'b1; tick("R5"); tick("R5");
        strobe("R7");
        // R6: clear force host mid-session, only full speed
        wr(1'b0, 1'b0, 1'b1, "R6");
        tick("R6");
        strobe("R8");
        sess_i = 1'b0; tick("R6");
        sess_i = 1'b1; tick("R6"); tick("R6");
        // R9: both speeds
        wr(1'b0, 1'b1, 1'b1, "R13");
        strobe("R9");
        // R10: neither, default 2'b11
        wr(1'b0, 1'b0, 1'b0, "R13");
        dflt_speed_i = 2'b11; strobe("R10");
        // R11: changes without a load keep the code
        dflt_speed_i = 2'b10; tick("R11");
        wr(1'b0, 1'b1, 1'b0, "R11");
        tick("R11");
        // R12: force host while session already running
        wr(1'b1, 1'b0, 1'b0, "R12");
        tick("R12"); tick("R12");
        // R11: entry loads speed (default path 2'b10)
        sess_i = 1'b0; tick("R11");
        sess_i = 1'b1; tick("R11"); tick("R11");
        sess_i = 1'b0; tick("R4");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule